// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block models a synchronous static memory built for cache-style burst traffic. Each word is 36 bits wide and is split into four 9-bit lanes. Every control, address and write-data input is sampled on the rising clock edge. Read data leaves through an output register, so one address can be accepted on every clock while earlier reads are still on their way out. A burst opens on either of two address strobes. After that, a 2-bit counter walks the low address bits, in either linear or interleaved order, for as long as the advance input asks it to.

Writes cover one to four lanes. They are chosen per lane under a lane-write gate, or all four at once through a global write input. Three chip selects, with mixed polarity, decide whether a strobe cycle selects the part. An asynchronous output enable gates the output driver, and a sleep input freezes the interface. When sleep drops, the interface stays frozen for a fixed three-clock recovery. The depth is a parameter, and 16 address bits give the nominal 64K words. The default is kept small.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is applied and after it is released, the output drive enable `dq_en` is low, and no burst is open until a strobe selects the part.
- R2: For a read whose address is sampled at clock edge N, `dq_out` carries the addressed word after edge N+1, and `dq_en` is high for exactly that one cycle when `oe_n` is low.
- R3: `dq_en` is low whenever `oe_n` is high, and it follows `oe_n` without waiting for a clock edge.
- R4: Lane k occupies `dq_out`/`wdata` bits [9k+8:9k], with the parity bit on top. With `gwr_n` high and `bwe_n` low, each lane whose `bw_n[k]` is low is written and the other lanes keep their contents.
- R5: With `gwr_n` high and `bwe_n` high, no lane is written whatever `bw_n` holds, and the cycle acts as a read.
- R6: With `gwr_n` low, all four lanes are written whatever `bwe_n` and `bw_n` hold.
- R7: A cycle started by `strb_cpu_n` low is always a read, even when write controls are active. Later cycles of that burst write if write controls are active in them.
- R8: A cycle started by `strb_ctl_n` low while write controls are active writes `wdata` at the external address.
- R9: In a burst cycle with no strobe and `adv_n` low, the 2-bit counter steps and wraps mod 4. The low two address bits become (base + count) mod 4 when `lin_mode` is 1 and base XOR count when `lin_mode` is 0. The upper address bits stay those of the base.
- R10: In a burst cycle with no strobe and `adv_n` high, the previous burst address is used again.
- R11: A strobe cycle without `ce1_n` low, `ce2` high and `ce3_n` low performs no access and closes the burst. Cycles after it, with no strobe, perform no access. Chip selects are not looked at in cycles without a strobe.
- R12: When both strobes are low in the same cycle, the processor strobe wins and the cycle is a read.
- R13: While `sleep` is high, and for the three clock edges after it falls, strobes and writes have no effect and memory contents are kept. The fourth edge after the fall accepts a cycle normally.
- R14: A clock cycle that follows a write, an idle cycle or a deselect leaves `dq_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| addr | input | ADDR_W | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| ce1_n | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low, always starts a read |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Lane-write gate, active low |
| bw_n | input | 4 | Per-lane write selects, active low |
| lin_mode | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 36 | Output register contents |
| dq_en | output | 1 | Drive enable of the tri-state output |

## Verification
The memory is first filled through controller-strobe global writes. It is then read with single-cycle processor starts, back to back, which checks the two-stage read latency and the one-cycle drive window. Lane-selective writes under several select patterns, followed by read-back, show whether the lane slicing and the lane-write gate are correct. A write attempted with the gate closed separates a read-only cycle from a silently dropped write. Bursts from odd base addresses in both orders, with advance held off part of the time, tell linear order from interleaved order, a stalled burst from a stepping one, and the counter wrap from a carry into the upper address bits. Each chip select is pulled alone, sleep windows are entered with writes pending, both strobes are raised together, and a long random stretch mixes all of these.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sbsram_wake_ctrl.sv
module sbsram_wake_ctrl #(
  parameter int WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_i,
  output logic quiet_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sleep_i)
      cnt_d = WAKE_CYC[CW-1:0];
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign quiet_o = sleep_i | (cnt_q != '0);

  // R13: the recovery window is still open on the edge where sleep falls
  p_recover_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_i) |-> quiet_o);
endmodule

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          quiet_i,
  input  logic          sel_i,
  input  logic          strb_p_i,
  input  logic          strb_c_i,
  input  logic          adv_i,
  input  logic          lin_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LANES-1:0] mask_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o,
  output logic [LANES-1:0] mask_o
);
  logic          active_q, active_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    cnt_q, cnt_d;
  logic [1:0]    step, lo;
  logic          wr_req;

  assign wr_req = (mask_i != '0);

  always_comb begin
    step     = cnt_q + {1'b0, adv_i};
    lo       = lin_i ? (base_q[1:0] + step) : (base_q[1:0] ^ step);
    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    op_o     = OP_IDLE;
    addr_o   = base_q;
    mask_o   = '0;
    if (!quiet_i) begin
      if (strb_p_i || strb_c_i) begin
        if (!sel_i) begin
          active_d = 1'b0;
        end else begin
          active_d = 1'b1;
          base_d   = addr_i;
          cnt_d    = 2'd0;
          addr_o   = addr_i;
          if (strb_p_i || !wr_req) begin
            op_o = OP_READ;
          end else begin
            op_o   = OP_WRITE;
            mask_o = mask_i;
          end
        end
      end else if (active_q) begin
        cnt_d  = step;
        addr_o = {base_q[AW-1:2], lo};
        if (wr_req) begin
          op_o   = OP_WRITE;
          mask_o = mask_i;
        end else begin
          op_o = OP_READ;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (active_d) begin
        base_q <= base_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  // R9: an advancing burst cycle moves the counter by exactly one
  p_ctr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet_i && !strb_p_i && !strb_c_i && active_q && adv_i)
      |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R11: an unselected strobe closes the burst
  p_desel_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!quiet_i && (strb_p_i || strb_c_i) && !sel_i) |=> !active_q);
endmodule

// File: rtl/sbsram_lane_array.sv
module sbsram_lane_array
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANES-1:0]  mask_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_i && mask_i[g])
        mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_i)
        q <= mem[addr_i];
    end

    assign rd_data_o[g*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid_o <= 1'b0;
    else        rd_valid_o <= rd_i;
  end

  // R14: a write cycle is never followed by valid read data
  p_wr_no_data_r14: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> !rd_valid_o);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbsram_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int WAKE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [35:0]       wdata,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              strb_cpu_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              gwr_n,
  input  logic              bwe_n,
  input  logic [3:0]        bw_n,
  input  logic              lin_mode,
  input  logic              sleep,
  input  logic              oe_n,
  output logic [35:0]       dq_out,
  output logic              dq_en
);
  logic              rst_meta, rst_s;
  logic              quiet, sel;
  logic [LANES-1:0]  wr_mask, c_mask;
  op_e               c_op;
  logic [ADDR_W-1:0] c_addr;
  op_e               s1_op, s1_op_d;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_mask;
  logic [WORD_W-1:0] s1_wdata;
  logic              s1_load;
  logic              rd_valid;
  logic [WORD_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_meta, rst_s} <= 2'b00;
    else        {rst_meta, rst_s} <= {1'b1, rst_meta};
  end

  assign sel = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (!gwr_n)      wr_mask = '1;
    else if (!bwe_n) wr_mask = ~bw_n;
    else             wr_mask = '0;
  end

  sbsram_wake_ctrl #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_s), .sleep_i(sleep), .quiet_o(quiet)
  );

  sbsram_burst_gen #(.AW(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_s), .quiet_i(quiet), .sel_i(sel),
    .strb_p_i(!strb_cpu_n), .strb_c_i(!strb_ctl_n), .adv_i(!adv_n),
    .lin_i(lin_mode), .addr_i(addr), .mask_i(wr_mask),
    .op_o(c_op), .addr_o(c_addr), .mask_o(c_mask)
  );

  assign s1_op_d = c_op;
  assign s1_load = (c_op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) s1_op <= OP_IDLE;
    else        s1_op <= s1_op_d;
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_addr  <= c_addr;
      s1_mask  <= c_mask;
      s1_wdata <= wdata;
    end
  end

  sbsram_lane_array #(.AW(ADDR_W)) u_array (
    .clk(clk), .rst_n(rst_s),
    .rd_i(s1_op == OP_READ), .wr_i(s1_op == OP_WRITE),
    .addr_i(s1_addr), .mask_i(s1_mask), .wdata_i(s1_wdata),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  assign dq_out = rd_data;
  assign dq_en  = !oe_n && rd_valid;

  // R7: a selected processor-strobe cycle is registered as a read
  p_cpu_read_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (!quiet && !strb_cpu_n && sel) |=> (s1_op == OP_READ));

  // R13: a frozen cycle registers no access
  p_quiet_idle_r13: assert property (@(posedge clk) disable iff (!rst_s)
    quiet |=> (s1_op == OP_IDLE));
endmodule

// File: tb/sync_burst_sram_tb.sv
`timescale 1ns/100ps
module sync_burst_sram_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [35:0] wdata;
  logic        ce1_n, ce2, ce3_n, strb_cpu_n, strb_ctl_n, adv_n;
  logic        gwr_n, bwe_n, lin_mode, sleep, oe_n;
  logic [3:0]  bw_n;
  logic [35:0] dq_out;
  logic        dq_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  sync_burst_sram u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .gwr_n(gwr_n), .bwe_n(bwe_n), .bw_n(bw_n), .lin_mode(lin_mode),
    .sleep(sleep), .oe_n(oe_n), .dq_out(dq_out), .dq_en(dq_en)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [35:0] mm [0:255];
  int          m_active, m_base, m_cnt, m_wk;
  int          p_op, p_addr, p_mask;
  logic [35:0] p_wd;
  bit          exp_valid;
  logic [35:0] exp_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_wk = 0; p_op = 0; exp_valid = 0;
    end else begin
      int mask, low;
      bit quiet;
      exp_valid = 0;
      if (p_op == 2)
        for (int l = 0; l < 4; l++)
          if (p_mask[l]) mm[p_addr][l*9 +: 9] = p_wd[l*9 +: 9];
      if (p_op == 1) begin
        exp_valid = 1;
        exp_data  = mm[p_addr];
      end
      quiet = sleep || (m_wk != 0);
      if (sleep) m_wk = 3;
      else if (m_wk > 0) m_wk = m_wk - 1;
      if (!gwr_n)      mask = 15;
      else if (!bwe_n) mask = int'(~bw_n) & 15;
      else             mask = 0;
      p_op = 0;
      if (!quiet) begin
        if (!strb_cpu_n || !strb_ctl_n) begin
          if (ce1_n || !ce2 || ce3_n) m_active = 0;
          else begin
            m_active = 1; m_base = int'(addr); m_cnt = 0;
            p_addr = int'(addr);
            p_op   = (!strb_cpu_n || mask == 0) ? 1 : 2;
            p_mask = mask; p_wd = wdata;
          end
        end else if (m_active != 0) begin
          if (!adv_n) m_cnt = (m_cnt + 1) % 4;
          low    = lin_mode ? ((m_base % 4) + m_cnt) % 4 : ((m_base % 4) ^ m_cnt);
          p_addr = m_base - (m_base % 4) + low;
          p_op   = (mask != 0) ? 2 : 1;
          p_mask = mask; p_wd = wdata;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_en;
      e_en = exp_valid && !oe_n;
      chk(dq_en == e_en, cur_req, {35'd0, dq_en}, {35'd0, e_en});
      if (e_en) chk(dq_out == exp_data, cur_req, dq_out, exp_data);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic idle_in();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1; gwr_n = 1; bwe_n = 1;
    bw_n = 4'hF; ce1_n = 0; ce2 = 1; ce3_n = 0;
  endtask

  task automatic cyc(input bit p, input bit c, input bit adv,
                     input bit gw, input bit be, input logic [3:0] bw,
                     input logic [7:0] a, input logic [35:0] d);
    strb_cpu_n = !p; strb_ctl_n = !c; adv_n = !adv;
    gwr_n = !gw; bwe_n = !be; bw_n = bw; addr = a; wdata = d;
    tick();
  endtask

  function automatic logic [35:0] pat(input int i);
    return {4'h9 ^ i[3:0], 32'hC0DE_0000 + 32'(i * 32'h0001_0203)};
  endfunction

  initial begin
    rst_n = 0; idle_in(); addr = 0; wdata = 0; lin_mode = 1; sleep = 0; oe_n = 0;
    repeat (3) tick();
    chk(dq_en == 1'b0, "R1", {35'd0, dq_en}, 36'd0);   // R1 during reset
    rst_n = 1;
    repeat (4) tick();
    cur_req = "R1";
    chk(dq_en == 1'b0, "R1", {35'd0, dq_en}, 36'd0);
    // no burst open: continuation cycle must not access
    cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 36'h0); cyc(0, 0, 0, 0, 0, 4'hF, 8'h00, 36'h0);

    cur_req = "R6";   // global write ignores lane selects
    for (int i = 0; i < 64; i++)
      cyc(0, 1, 0, 1, i[0], 4'(i), 8'(i), pat(i));
    cur_req = "R14"; idle_in(); tick(); tick();

    cur_req = "R2";   // back-to-back single reads
    for (int i = 0; i < 64; i++) cyc(1, 0, 0, 0, 0, 4'hF, 8'(i), 36'h0);
    idle_in(); tick(); tick();

    cur_req = "R4";   // lane-selective writes, read back
    cyc(0, 1, 0, 0, 1, 4'b1010, 8'h10, 36'hA_AAAA_AAAA);
    cyc(0, 1, 0, 0, 1, 4'b0111, 8'h11, 36'h5_5555_5555);
    cyc(0, 1, 0, 0, 1, 4'b0000, 8'h12, 36'hF_0F0F_0F0F);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h10, 0); cyc(1, 0, 0, 0, 0, 4'hF, 8'h11, 0);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h12, 0); idle_in(); tick(); tick();

    cur_req = "R5";   // gate closed: acts as a read, no lane changes
    cyc(0, 1, 0, 0, 0, 4'h0, 8'h13, 36'h0_0000_0000);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h13, 0); idle_in(); tick(); tick();

    cur_req = "R7";   // cpu start ignores writes; later cycles write
    cyc(1, 0, 0, 1, 0, 4'hF, 8'h21, 36'h1_1111_1111);
    cyc(0, 0, 1, 1, 0, 4'hF, 8'h00, 36'h2_2222_2222);
    cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 0);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h22, 0); idle_in(); tick(); tick();

    cur_req = "R8";
    cyc(0, 1, 0, 1, 0, 4'hF, 8'h24, 36'h3_3333_3333);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h24, 0); idle_in(); tick(); tick();

    cur_req = "R9";   // both orders from an odd base, with wrap
    for (int m = 0; m < 2; m++) begin
      lin_mode = m[0];
      cyc(1, 0, 0, 0, 0, 4'hF, 8'h2D, 0);
      for (int k = 0; k < 6; k++) cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 0);
      cyc(1, 0, 0, 0, 0, 4'hF, 8'h32, 0);
      for (int k = 0; k < 5; k++) cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 0);
    end
    idle_in(); tick(); tick();

    cur_req = "R10";  // stalled burst reuses address
    lin_mode = 1;
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h05, 0);
    cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 0);
    cyc(0, 0, 0, 0, 0, 4'hF, 8'h00, 0);
    cyc(0, 0, 0, 0, 0, 4'hF, 8'h00, 0);
    cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 0); idle_in(); tick(); tick();

    cur_req = "R11";  // each select alone deselects; writes dropped
    for (int s = 0; s < 3; s++) begin
      cyc(1, 0, 0, 0, 0, 4'hF, 8'h08, 0);
      ce1_n = (s == 0); ce2 = (s != 1); ce3_n = (s == 2);
      cyc(0, 1, 0, 1, 0, 4'hF, 8'h08, 36'hD_EAD0_0000);
      ce1_n = 1; ce2 = 0; ce3_n = 1;   // ignored without strobe
      cyc(0, 0, 1, 1, 0, 4'hF, 8'h00, 36'hD_EAD0_0001);
      cyc(0, 0, 1, 0, 0, 4'hF, 8'h00, 0);
      idle_in();
      cyc(1, 0, 0, 0, 0, 4'hF, 8'h08, 0);
    end
    idle_in(); tick(); tick();

    cur_req = "R12";  // both strobes: read wins
    cyc(1, 1, 0, 1, 0, 4'hF, 8'h09, 36'h7_7777_7777);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h09, 0); idle_in(); tick(); tick();

    cur_req = "R3";   // output enable gating, including mid-cycle change
    oe_n = 1;
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h01, 0);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h02, 0);
    oe_n = 0; #0.5;
    chk(dq_en == 1'b1, "R3", {35'd0, dq_en}, 36'd1);
    oe_n = 1; #0.5;
    chk(dq_en == 1'b0, "R3", {35'd0, dq_en}, 36'd0);
    oe_n = 0;
    idle_in(); tick(); tick();

    cur_req = "R13";  // sleep and recovery freeze the interface
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h30, 0);
    sleep = 1;
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, 0, 4'hF, 8'h30, 36'hB_AD00_0000 + k);
    sleep = 0;
    for (int k = 0; k < 3; k++) cyc(0, 1, 1, 1, 0, 4'hF, 8'h30, 36'hB_AD00_0010 + k);
    cyc(1, 0, 0, 0, 0, 4'hF, 8'h30, 0);
    idle_in(); tick(); tick();

    cur_req = "R2";   // random mix
    for (int i = 0; i < 400; i++) begin
      strb_cpu_n = ($urandom % 4) != 0; strb_ctl_n = ($urandom % 4) != 0;
      adv_n = $urandom % 2; gwr_n = ($urandom % 4) != 0;
      bwe_n = $urandom % 2; bw_n = 4'($urandom);
      ce1_n = ($urandom % 8) == 0; ce2 = ($urandom % 8) != 0; ce3_n = ($urandom % 8) == 0;
      lin_mode = $urandom % 2; oe_n = ($urandom % 6) == 0;
      sleep = ($urandom % 40) == 0;
      addr = 8'($urandom % 64); wdata = {4'($urandom), 32'($urandom)};
      tick();
    end
    sleep = 0; oe_n = 0; idle_in();
    repeat (8) tick();

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule